// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Controller

This block is the synchronous control logic for an 8-input by 4-output routing matrix. A host stages one route per output over a small parallel bus. Each staged entry holds an enable bit and an input index. The staged routes do not reach the matrix until a salvo strobe copies every staged entry into the active set in a single clock edge. The active set is decoded into a one-hot switch-enable vector for the analog matrix and into one active-low disable flag per output. The disable flags can put an idle output driver to sleep.

Because staging and activation are separate, several controllers can be loaded one at a time by chip select and then switched together by one shared salvo. A functional clear input opens every crosspoint but keeps the staged routes, so a later salvo brings the earlier routing back. A readback path returns the active entry of a chosen output, with an output-enable flag that drives a tri-state pad outside this block. All strobes are active low and are sampled on the system clock. They are assumed to be synchronous to it.

Top module: `xbar_route_ctrl`

## Requirements
- R1: An entry is 4 bits. Bit 3 is the enable and bits 2..0 are the input index. Index 0..7 selects input 1..8 when bit 3 is 1. When bit 3 is 0 the output is off and the index is ignored.
- R2: `out_sel` code 0..3 addresses output 1..4. A staged entry takes `addr_in` on the clock edge where `wr_n` is sampled 1 after being sampled 0 on the previous edge, provided `cs_n`=0, `dir`=0 and `clr_n`=1 are sampled on that edge. Otherwise the staged entries are unchanged.
- R3: A staged write by itself changes neither `sw_en`, `dis_n` nor the readback value.
- R4: On every edge where `salvo_n`=0 and `clr_n`=1 are sampled, all four active entries take the staged values they held before that edge. A staged write on the same edge is not copied.
- R5: On an edge where `clr_n`=0 is sampled, all active entries become off, whatever `salvo_n` is. The staged entries are kept, so a later salvo restores them.
- R6: `sw_en` bit o*8+i is 1 exactly when output o's active entry is enabled with index i. Each 8-bit output group therefore has at most one bit set.
- R7: `dis_n[o]` is 0 exactly when output o's active entry is off, which includes the state after a clear.
- R8: After an edge that samples `cs_n`=0, `dir`=1, `wr_n`=1 and `salvo_n`=1, `addr_oe`=1 and `addr_out` holds the active entry addressed by `out_sel`. After any other edge, `addr_oe`=0 and `addr_out`=0.
- R9: Synchronous `rst`=1 clears both the staged and the active entries. After that edge `sw_en`=0, `dis_n`=0 and `addr_oe`=0.
- R10: One input may be routed to several outputs at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| cs_n | input | 1 | Active-low chip select |
| dir | input | 1 | 0 = stage a write, 1 = read back |
| wr_n | input | 1 | Active-low write strobe; commits on its rising edge |
| salvo_n | input | 1 | Active-low level: copy staged set into active set |
| clr_n | input | 1 | Active-low level: open all crosspoints |
| out_sel | input | 2 | Output address for write or readback |
| addr_in | input | 4 | Entry to stage (enable, index) |
| addr_out | output | 4 | Readback of the selected active entry |
| addr_oe | output | 1 | Drive enable for the readback pads |
| sw_en | output | 32 | One-hot switch enables, bit output*8+input |
| dis_n | output | 4 | Active-low per-output disable flags |

## Verification
A wrong staged entry stays hidden at `sw_en` until the next salvo. The bench therefore checks the outputs both before a salvo, where nothing may move, and one edge after it. A wrong active entry shows at once at `sw_en` and `dis_n` on the edge after the salvo. It also shows at the readback one edge after a read is requested. The sweep walks every entry code through every output, so a wrong index decode, a misplaced group or a stuck enable bit appears within one salvo of the code that exposes it.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_N_IN_DEF  = 8;
  localparam int XB_N_OUT_DEF = 4;
  typedef enum logic {XB_DIR_WRITE = 1'b0, XB_DIR_READ = 1'b1} xb_dir_e;
endpackage

// File: rtl/xbar_stage_bank.sv
module xbar_stage_bank #(
  parameter int N_OUT = 4,
  parameter int ENT_W = 4,
  parameter int SEL_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cs_n,
  input  logic                         dir,
  input  logic                         wr_n,
  input  logic                         clr_n,
  input  logic [SEL_W-1:0]             out_sel,
  input  logic [ENT_W-1:0]             addr_in,
  output logic [N_OUT-1:0][ENT_W-1:0]  staged
);
  logic wr_q;
  logic commit;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  // rising edge of the write strobe, qualified by select, direction and clear
  assign commit = wr_n && !wr_q && !cs_n && (dir == xbar_pkg::XB_DIR_WRITE) && clr_n;

  for (genvar o = 0; o < N_OUT; o++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                                   staged[o] <= '0;
      else if (commit && out_sel == SEL_W'(o))   staged[o] <= addr_in;
    end
  end

  // R2
  no_write_unselected_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(staged));
endmodule

// File: rtl/xbar_active_bank.sv
module xbar_active_bank #(
  parameter int N_OUT = 4,
  parameter int ENT_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         salvo_n,
  input  logic                         clr_n,
  input  logic [N_OUT-1:0][ENT_W-1:0]  staged,
  output logic [N_OUT-1:0][ENT_W-1:0]  active_d,
  output logic [N_OUT-1:0][ENT_W-1:0]  active_q
);
  always_comb begin
    active_d = active_q;
    if (!clr_n)        active_d = '0;
    else if (!salvo_n) active_d = staged;
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active_d;
  end

  // R4
  salvo_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!salvo_n && clr_n) |=> (active_q == $past(staged)));
endmodule

// File: rtl/xbar_route_decode.sv
module xbar_route_decode #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int IDX_W = 3,
  parameter int ENT_W = 4
) (
  input  logic [N_OUT-1:0][ENT_W-1:0] entries,
  output logic [N_OUT*N_IN-1:0]       sw_vec,
  output logic [N_OUT-1:0]            dis_vec_n
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign dis_vec_n[o] = entries[o][ENT_W-1];
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign sw_vec[o*N_IN+i] = entries[o][ENT_W-1] &&
                                (entries[o][IDX_W-1:0] == IDX_W'(i));
    end
  end
endmodule

// File: rtl/xbar_route_ctrl.sv
module xbar_route_ctrl #(
  parameter int N_IN  = xbar_pkg::XB_N_IN_DEF,
  parameter int N_OUT = xbar_pkg::XB_N_OUT_DEF,
  localparam int IDX_W = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int ENT_W = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    dir,
  input  logic                    wr_n,
  input  logic                    salvo_n,
  input  logic                    clr_n,
  input  logic [SEL_W-1:0]        out_sel,
  input  logic [ENT_W-1:0]        addr_in,
  output logic [ENT_W-1:0]        addr_out,
  output logic                    addr_oe,
  output logic [N_OUT*N_IN-1:0]   sw_en,
  output logic [N_OUT-1:0]        dis_n
);
  logic [N_OUT-1:0][ENT_W-1:0] staged;
  logic [N_OUT-1:0][ENT_W-1:0] active_d;
  logic [N_OUT-1:0][ENT_W-1:0] active_q;
  logic [N_OUT*N_IN-1:0]       sw_d;
  logic [N_OUT-1:0]            dis_d;
  logic                        rd_req;

  xbar_stage_bank #(.N_OUT(N_OUT), .ENT_W(ENT_W), .SEL_W(SEL_W)) u_stage (
    .clk(clk), .rst(rst), .cs_n(cs_n), .dir(dir), .wr_n(wr_n), .clr_n(clr_n),
    .out_sel(out_sel), .addr_in(addr_in), .staged(staged));

  xbar_active_bank #(.N_OUT(N_OUT), .ENT_W(ENT_W)) u_active (
    .clk(clk), .rst(rst), .salvo_n(salvo_n), .clr_n(clr_n),
    .staged(staged), .active_d(active_d), .active_q(active_q));

  xbar_route_decode #(.N_IN(N_IN), .N_OUT(N_OUT), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_dec (
    .entries(active_d), .sw_vec(sw_d), .dis_vec_n(dis_d));

  // outputs are registered on the same edge that updates the active set
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en <= '0;
      dis_n <= '0;
    end else begin
      sw_en <= sw_d;
      dis_n <= dis_d;
    end
  end

  assign rd_req = !cs_n && (dir == xbar_pkg::XB_DIR_READ) && wr_n && salvo_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_oe  <= 1'b0;
      addr_out <= '0;
    end else begin
      addr_oe  <= rd_req;
      addr_out <= rd_req ? active_d[out_sel] : '0;
    end
  end

  // R5
  clr_opens_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (sw_en == '0 && dis_n == '0));

  // R8
  no_readback_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (dir == xbar_pkg::XB_DIR_WRITE) |=> !addr_oe);

  // R3
  hold_without_salvo_chk: assert property (@(posedge clk) disable iff (rst)
    (salvo_n && clr_n) |=> $stable(sw_en));

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    // R6
    one_input_per_output_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sw_en[o*N_IN +: N_IN]));
  end
endmodule

// File: tb/test_xbar_route_ctrl.sv
module test_xbar_route_ctrl;
  localparam int NI = 8;
  localparam int NO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, dir = 1'b0, wr_n = 1'b1, salvo_n = 1'b1, clr_n = 1'b1;
  logic [1:0] out_sel = '0;
  logic [3:0] addr_in = '0;
  logic [3:0] addr_out;
  logic addr_oe;
  logic [31:0] sw_en;
  logic [3:0] dis_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] m_stage [NO];
  logic [3:0] m_act [NO];

  always #10 clk = ~clk;

  xbar_route_ctrl i_xbar_route_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .dir(dir), .wr_n(wr_n), .salvo_n(salvo_n),
    .clr_n(clr_n), .out_sel(out_sel), .addr_in(addr_in), .addr_out(addr_out),
    .addr_oe(addr_oe), .sw_en(sw_en), .dis_n(dis_n));

  function automatic logic [31:0] exp_sw();
    logic [31:0] v = '0;
    for (int o = 0; o < NO; o++)
      if (m_act[o][3]) v[o*NI + int'(m_act[o][2:0])] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] exp_dis();
    logic [3:0] v;
    for (int o = 0; o < NO; o++) v[o] = m_act[o][3];
    return v;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_route(string req);
    cmp({req, " sw_en"}, sw_en, exp_sw());
    cmp({req, " dis_n"}, {28'd0, dis_n}, {28'd0, exp_dis()});
  endtask

  task automatic stage(int o, logic [3:0] code, logic cs, logic d);
    @(negedge clk);
    out_sel = 2'(o); addr_in = code; cs_n = cs; dir = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; dir = 1'b0;
    if (!cs && !d) m_stage[o] = code;
  endtask

  task automatic salvo();
    @(negedge clk); salvo_n = 1'b0;
    @(negedge clk); salvo_n = 1'b1;
    for (int o = 0; o < NO; o++) m_act[o] = m_stage[o];
  endtask

  task automatic readback(int o, string req);
    @(negedge clk); cs_n = 1'b0; dir = 1'b1; out_sel = 2'(o);
    @(negedge clk);
    cmp({req, " oe"}, {31'd0, addr_oe}, 32'd1);
    cmp({req, " data"}, {28'd0, addr_out}, {28'd0, m_act[o]});
    cs_n = 1'b1; dir = 1'b0;
    @(negedge clk);
    cmp({req, " oe off"}, {31'd0, addr_oe}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int o = 0; o < NO; o++) begin m_stage[o] = '0; m_act[o] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk_route("R9 reset");
    cmp("R9 oe", {31'd0, addr_oe}, 32'd0);

    // R1 R6 R7 R8: sweep all entry codes through all outputs
    for (int c = 0; c < 16; c++) begin
      for (int o = 0; o < NO; o++) stage(o, 4'((c + 5*o) % 16), 1'b0, 1'b0);
      chk_route("R3 before salvo");
      readback(c % NO, "R3 readback shows active");
      salvo();
      chk_route("R1 R4 R6 R7 after salvo");
      for (int o = 0; o < NO; o++) readback(o, "R8 readback");
    end

    // R10: input 6 (index 5) to every output
    for (int o = 0; o < NO; o++) stage(o, 4'b1101, 1'b0, 1'b0);
    salvo();
    cmp("R10 fanout", sw_en, 32'h2020_2020);

    // R2: ignored when chip select high or direction read
    stage(2, 4'b1000, 1'b1, 1'b0);
    stage(1, 4'b1001, 1'b0, 1'b1);
    salvo();
    chk_route("R2 ignored write");
    cmp("R2 ignored write value", sw_en, 32'h2020_2020);

    // R2: strobe held low without rising edge commits nothing
    @(negedge clk); cs_n = 1'b0; out_sel = 2'd0; addr_in = 4'b1010; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    salvo();
    chk_route("R2 no edge no commit");

    // R5: clear opens all, staged kept, salvo restores
    stage(3, 4'b1111, 1'b0, 1'b0);
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
    for (int o = 0; o < NO; o++) m_act[o] = '0;
    chk_route("R5 clear");
    cmp("R5 clear sw", sw_en, 32'd0);
    readback(3, "R5 readback after clear");
    salvo();
    chk_route("R5 restore");
    cmp("R5 restore value", sw_en, 32'h8020_2020);

    // R5: clear beats salvo on the same edge
    @(negedge clk); clr_n = 1'b0; salvo_n = 1'b0;
    @(negedge clk); clr_n = 1'b1; salvo_n = 1'b1;
    for (int o = 0; o < NO; o++) m_act[o] = '0;
    chk_route("R5 clear wins");

    // R4: write and salvo on the same edge, old staged value copied
    salvo();
    @(negedge clk); cs_n = 1'b0; out_sel = 2'd1; addr_in = 4'b1011; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; salvo_n = 1'b0;
    @(negedge clk); salvo_n = 1'b1; cs_n = 1'b1;
    for (int o = 0; o < NO; o++) m_act[o] = m_stage[o];
    m_stage[1] = 4'b1011;
    chk_route("R4 same-edge write not copied");
    salvo();
    chk_route("R4 later salvo copies write");

    // R9: synchronous reset clears staged set too
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int o = 0; o < NO; o++) begin m_stage[o] = '0; m_act[o] = '0; end
    chk_route("R9 reset outputs");
    salvo();
    chk_route("R9 staged cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule